// File: doc/BRIEF.md
# Bus Inversion Codec

This block encodes and decodes data for a 64-bit active-low parallel bus. The bus is split into four lane groups of 16 bits. On the transmit side, the block counts how many lines in each group would be driven low. If that count goes above half the group width, it sends the whole group complemented and raises that group's inversion flag. As a result, no group ever drives more than 8 of its 16 lines low. The data and the four flags leave the block together, from one register stage, one cycle after they are accepted.

The receive side does the reverse. It takes the bus word and the four flags, complements each flagged group, passes the other groups through unchanged and registers the restored word. Both paths carry a valid bit of their own.

Signal polarity is kept logical inside the block. A 1 on a bus bit means that line is driven low, and a 1 on a flag means that flag is asserted (driven low). Pad drivers outside the block turn these into electrical levels.

Top module: `bus_invert_codec`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted word, `tx_valid_o` and `rx_valid_o` are 0, and `tx_bus_o`, `tx_flip_o` and `rx_data_o` are all zero.
- R2: Flag bit g covers data bits [16g+15:16g]. Flag 0 covers bits 15:0 and flag 3 covers bits 63:48. Deciding or undoing the inversion of one group never changes bits of another group.
- R3: A transmit group whose input holds more than 8 one-bits (lines driven low) is sent complemented, and its flag bit is 1.
- R4: A transmit group whose input holds 8 or fewer one-bits is sent unchanged, and its flag bit is 0. This includes exactly 8.
- R5: Whenever `tx_valid_o` is 1, every 16-bit group of `tx_bus_o` holds at most 8 one-bits.
- R6: A word presented with `tx_valid_i`=1 at a rising edge appears on `tx_bus_o`/`tx_flip_o` right after that edge, with `tx_valid_o`=1. `tx_valid_o` is otherwise 0 after the next edge.
- R7: When `tx_valid_i` is 0 at an edge, `tx_bus_o` and `tx_flip_o` keep their values whatever `tx_data_i` holds.
- R8: A word presented with `rx_valid_i`=1 at a rising edge appears on `rx_data_o` right after that edge, with `rx_valid_o`=1. Groups whose `rx_flip_i` bit is 1 are complemented, and the other groups are passed through unchanged.
- R9: Feeding the transmit outputs into the receive inputs returns the original 64-bit word.
- R10: When `rx_valid_i` is 0 at an edge, `rx_data_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Transmit word present |
| tx_data_i | input | 64 | Transmit word, 1 = line to be driven low |
| tx_valid_o | output | 1 | Transmit output word valid |
| tx_bus_o | output | 64 | Encoded bus word |
| tx_flip_o | output | 4 | Per-group inversion flag, 1 = asserted |
| rx_valid_i | input | 1 | Receive word present |
| rx_bus_i | input | 64 | Received bus word |
| rx_flip_i | input | 4 | Received inversion flags |
| rx_valid_o | output | 1 | Restored word valid |
| rx_data_o | output | 64 | Restored word |

## Verification
The bench builds the codec with its default parameters: four groups of 16 bits. With that width, weight boundaries of 8 and 9 one-bits can be placed in any chosen group, and the mapping of each flag to its own slice can be shown group by group. Random words from a fixed seed, with the probability of a one-bit varied per run segment, push group weights across the whole 0..16 range. Each random word is then looped from the transmit outputs back into the receive inputs.

// File: rtl/bic_pkg.sv
package bic_pkg;

  localparam int unsigned DEF_GROUPS  = 4;
  localparam int unsigned DEF_GROUP_W = 16;

  // Number of set bits in the low 'w' bits of v.
  function automatic int unsigned bit_weight(input logic [63:0] v, input int unsigned w);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < w) n += int'(v[i]);
    end
    return n;
  endfunction

  // A group is sent complemented only when strictly more than half its lines would go low.
  function automatic logic flip_needed(input int unsigned weight, input int unsigned w);
    return weight > (w / 2);
  endfunction

endpackage

// File: rtl/bic_grp_enc.sv
module bic_grp_enc #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] data_i,
  output logic [W-1:0] bus_o,
  output logic         flip_o
);
  import bic_pkg::*;

  logic [63:0] wide;
  int unsigned weight;

  always_comb begin
    wide = '0;
    wide[W-1:0] = data_i;
    weight = bit_weight(wide, W);
    flip_o = flip_needed(weight, W);
    bus_o  = flip_o ? ~data_i : data_i;
  end

endmodule

// File: rtl/bic_grp_dec.sv
module bic_grp_dec #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] bus_i,
  input  logic         flip_i,
  output logic [W-1:0] data_o
);
  always_comb begin
    data_o = bus_i ^ {W{flip_i}};
  end

endmodule

// File: rtl/bus_invert_codec.sv
module bus_invert_codec #(
  parameter int unsigned GROUPS  = bic_pkg::DEF_GROUPS,
  parameter int unsigned GROUP_W = bic_pkg::DEF_GROUP_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tx_valid_i,
  input  logic [GROUPS*GROUP_W-1:0]   tx_data_i,
  output logic                        tx_valid_o,
  output logic [GROUPS*GROUP_W-1:0]   tx_bus_o,
  output logic [GROUPS-1:0]           tx_flip_o,
  input  logic                        rx_valid_i,
  input  logic [GROUPS*GROUP_W-1:0]   rx_bus_i,
  input  logic [GROUPS-1:0]           rx_flip_i,
  output logic                        rx_valid_o,
  output logic [GROUPS*GROUP_W-1:0]   rx_data_o
);
  localparam int unsigned DATA_W = GROUPS * GROUP_W;
  localparam int unsigned LIMIT  = GROUP_W / 2;

  // Combinational results of the per-group logic, named for the checks below.
  logic [DATA_W-1:0] enc_bus;
  logic [GROUPS-1:0] enc_flip;
  logic [DATA_W-1:0] dec_data;

  for (genvar g = 0; g < GROUPS; g++) begin : g_lane
    bic_grp_enc #(.W(GROUP_W)) u_enc (
      .data_i (tx_data_i[g*GROUP_W +: GROUP_W]),
      .bus_o  (enc_bus[g*GROUP_W +: GROUP_W]),
      .flip_o (enc_flip[g])
    );
    bic_grp_dec #(.W(GROUP_W)) u_dec (
      .bus_i  (rx_bus_i[g*GROUP_W +: GROUP_W]),
      .flip_i (rx_flip_i[g]),
      .data_o (dec_data[g*GROUP_W +: GROUP_W])
    );

    // R5: a registered group never shows more than half its lines low
    assert_group_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o |-> ($countones(tx_bus_o[g*GROUP_W +: GROUP_W]) <= LIMIT));

    // R3: a flagged group came from a heavy word, so its sent form is light
    assert_flip_light_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && tx_flip_o[g]) |-> ($countones(tx_bus_o[g*GROUP_W +: GROUP_W]) < LIMIT));
  end

  // Transmit register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid_o <= 1'b0;
      tx_bus_o   <= '0;
      tx_flip_o  <= '0;
    end else begin
      tx_valid_o <= tx_valid_i;
      if (tx_valid_i) begin
        tx_bus_o  <= enc_bus;
        tx_flip_o <= enc_flip;
      end
    end
  end

  // Receive register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= rx_valid_i;
      if (rx_valid_i) rx_data_o <= dec_data;
    end
  end

  // R6: output valid is the input valid one cycle later
  assert_tx_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_i |=> tx_valid_o);

  // R7: no accepted word, no change on the transmit side
  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid_i |=> ($stable(tx_bus_o) && $stable(tx_flip_o)));

  // R10: no accepted word, no change on the receive side
  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_i |=> $stable(rx_data_o));

  // R8: receive valid tracks its input one cycle later
  assert_rx_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_i |=> rx_valid_o);

endmodule

// File: tb/bus_invert_codec_tb.sv
module bus_invert_codec_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_valid_i = 1'b0;
  logic [63:0] tx_data_i = '0;
  logic        tx_valid_o;
  logic [63:0] tx_bus_o;
  logic [3:0]  tx_flip_o;
  logic        rx_valid_i = 1'b0;
  logic [63:0] rx_bus_i = '0;
  logic [3:0]  rx_flip_i = '0;
  logic        rx_valid_o;
  logic [63:0] rx_data_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bus_invert_codec u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
    .tx_valid_o(tx_valid_o), .tx_bus_o(tx_bus_o), .tx_flip_o(tx_flip_o),
    .rx_valid_i(rx_valid_i), .rx_bus_i(rx_bus_i), .rx_flip_i(rx_flip_i),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
  );

  // Bench model: count lines per slice, complement a slice holding 9 or more.
  function automatic logic [3:0] model_flags(input logic [63:0] d);
    logic [3:0] f;
    for (int g = 0; g < 4; g++) begin
      int c = 0;
      for (int b = 0; b < 16; b++) if (d[16*g + b]) c++;
      f[g] = (c >= 9);
    end
    return f;
  endfunction

  function automatic logic [63:0] model_apply(input logic [63:0] d, input logic [3:0] f);
    logic [63:0] r;
    for (int g = 0; g < 4; g++)
      r[16*g +: 16] = f[g] ? ~d[16*g +: 16] : d[16*g +: 16];
    return r;
  endfunction

  function automatic int max_slice_weight(input logic [63:0] d);
    int m = 0;
    for (int g = 0; g < 4; g++) begin
      int c = 0;
      for (int b = 0; b < 16; b++) if (d[16*g + b]) c++;
      if (c > m) m = c;
    end
    return m;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_tx(input logic [63:0] d);
    @(negedge clk);
    tx_valid_i = 1'b1;
    tx_data_i  = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    tx_valid_i = 1'b0;
  endtask

  task automatic send_rx(input logic [63:0] b, input logic [3:0] f);
    @(negedge clk);
    rx_valid_i = 1'b1;
    rx_bus_i   = b;
    rx_flip_i  = f;
    @(posedge clk);
    #1;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  task automatic check_tx(input string req, input logic [63:0] d);
    logic [3:0] f;
    f = model_flags(d);
    send_tx(d);
    chk({req, " valid"}, {63'd0, tx_valid_o}, 64'd1);
    chk({req, " bus"}, tx_bus_o, model_apply(d, f));
    chk({req, " flags"}, {60'd0, tx_flip_o}, {60'd0, f});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] d, capb, held_bus;
    logic [3:0]  capf, held_f;
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));

    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk("R1 tx_valid in reset", {63'd0, tx_valid_o}, 64'd0);
    chk("R1 bus in reset", tx_bus_o, 64'd0);
    chk("R1 rx in reset", {rx_data_o[62:0], rx_valid_o}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 after release", {tx_bus_o[59:0], tx_flip_o}, 64'd0);
    chk("R1 valids after release", {62'd0, tx_valid_o, rx_valid_o}, 64'd0);

    // R4 all zero, R3 all one
    check_tx("R4 all-zero", 64'd0);
    chk("R4 all-zero flags", {60'd0, tx_flip_o}, 64'd0);
    check_tx("R3 all-one", {64{1'b1}});
    chk("R3 all-one bus", tx_bus_o, 64'd0);
    chk("R3 all-one flags", {60'd0, tx_flip_o}, 64'hF);
    // R4 exactly 8 in every slice stays
    check_tx("R4 weight8", 64'h00FF_0F0F_3333_5555);
    chk("R4 weight8 flags", {60'd0, tx_flip_o}, 64'd0);
    // R3 weight 9 in slice 0
    check_tx("R3 weight9", 64'h0000_0000_0000_01FF);
    chk("R3 weight9 bus", tx_bus_o, 64'h0000_0000_0000_FE00);
    // R2 one heavy slice at a time
    for (int g = 0; g < 4; g++) begin
      d = 64'h0101_0101_0101_0101;
      d[16*g +: 16] = 16'hFFF0;
      check_tx("R2 slice map", d);
      chk("R2 single flag", {60'd0, tx_flip_o}, 64'd1 << g);
    end

    // R6 latency: valid low one cycle later, and not yet high before the edge
    @(negedge clk);
    tx_valid_i = 1'b1;
    tx_data_i  = 64'hFFFF_0000_FFFF_0000;
    #1;
    chk("R6 not before edge", {63'd0, tx_valid_o}, 64'd0);
    @(posedge clk);
    #1;
    chk("R6 one cycle", tx_bus_o, 64'h0000_0000_0000_0000);
    chk("R6 flags", {60'd0, tx_flip_o}, 64'hA);
    @(negedge clk);
    tx_valid_i = 1'b0;
    @(posedge clk);
    #1;
    chk("R6 valid drops", {63'd0, tx_valid_o}, 64'd0);

    // R7 hold with changing data and valid low
    held_bus = tx_bus_o;
    held_f = tx_flip_o;
    @(negedge clk);
    tx_data_i = 64'h1234_FFFF_ABCD_0001;
    repeat (2) @(posedge clk);
    #1;
    chk("R7 bus hold", tx_bus_o, held_bus);
    chk("R7 flag hold", {60'd0, tx_flip_o}, {60'd0, held_f});

    // R8 receive directed
    send_rx(64'h1111_2222_3333_4444, 4'b0101);
    chk("R8 selective invert", rx_data_o, 64'h1111_DDDD_3333_BBBB);
    chk("R8 valid", {63'd0, rx_valid_o}, 64'd1);
    // R10 hold
    @(negedge clk);
    rx_bus_i = '1;
    rx_flip_i = 4'hF;
    repeat (2) @(posedge clk);
    #1;
    chk("R10 rx hold", rx_data_o, 64'h1111_DDDD_3333_BBBB);
    chk("R10 rx valid low", {63'd0, rx_valid_o}, 64'd0);

    // R9/R5 random round trips with varied density
    for (int i = 0; i < 300; i++) begin
      int dens;
      dens = i % 5;
      d = {$urandom(), $urandom()};
      case (dens)
        0: d = d & {$urandom(), $urandom()};
        1: d = d | {$urandom(), $urandom()};
        2: d = d & {$urandom(), $urandom()} & {$urandom(), $urandom()};
        3: d = d | {$urandom(), $urandom()} | {$urandom(), $urandom()};
        default: ;
      endcase
      check_tx("R3/R4 random", d);
      chk("R5 cap", {63'd0, (max_slice_weight(tx_bus_o) <= 8)}, 64'd1);
      capb = tx_bus_o;
      capf = tx_flip_o;
      send_rx(capb, capf);
      chk("R9 round trip", rx_data_o, d);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule